// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block stands between requesters and a small on-chip model of a flash array. It accepts three kinds of request: reading one word, programming one word, and erasing one erase block. It also offers a buffered mode that programs 32 consecutive words in one request. Every request carries a tag that names the requester: instruction fetch, data read, or debugger. Before any operation runs, the controller checks two policy vectors that hold one bit per protection region. A region is a pair of adjacent erase blocks. One vector allows modification of the region and the other allows reading it. A refused request leaves the array untouched, raises a violation pulse and returns zero data.

The array follows flash rules. Programming can only clear bits, so the stored word becomes the old word ANDed with the written word. Erasing sets every word of a block to all ones, one word per cycle. The policy bits start fully open after reset. They can only be cleared by policy writes, and the only way to set them again is a reset. A region whose modify bit is cleared and whose read bit is set is read-only. A region whose read bit is cleared is execute-only, which means only instruction fetches may read it.

Top module: `flash_prot_ctrl`

## Requirements
- R1: An erase request that is allowed writes all-ones into every word of the addressed erase block (`WORDS_PER_BLK` words, block = `req_addr[AW-1:8]` by default), one word per cycle; `done` rises `WORDS_PER_BLK+1` cycles after the accepting edge.
- R2: An allowed word program stores old AND written value, so a bit already at 0 never returns to 1; `done` follows one cycle after acceptance.
- R3: Protection regions span two adjacent erase blocks; region index = `req_addr[AW-1:9]` by default, so blocks 2k and 2k+1 share one modify bit and one read bit.
- R4: When a region's modify bit is 0, every program, erase and burst request to it is refused and the array keeps its contents.
- R5: A region with modify bit 0 and read bit 1 is read-only: reads from any requester return the stored word.
- R6: When a region's read bit is 0, reads tagged fetch (`req_src`=0) return data, while data (`req_src`=1) and debugger (`req_src`=2) reads are refused.
- R7: A burst request (`req_op`=3) programs the 32 words starting at `req_addr` with its low 5 bits cleared, taking word i from `wbuf_data` while `wbuf_idx`=i and applying the AND rule; the region check is made once, and `done` rises 33 cycles after acceptance.
- R8: A refused request gives `done` and `viol` high together for exactly one cycle, with `rd_data` zero.
- R9: After reset, `busy`, `done` and `viol` are low, every word reads as all ones, and every policy bit is set.
- R10: A policy write (`pol_we`) ANDs `pol_data` into the modify vector (`pol_kind`=0) or the read vector (`pol_kind`=1); a cleared bit is not set again by a later write.
- R11: While `busy` is high, which is during erase and burst, a new request is ignored: it produces no `done` and does not change the array.
- R12: Request codes: `req_op` 0 read, 1 program, 2 erase, 3 burst; every accepted request produces exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 burst |
| req_src | input | 2 | 0 fetch, 1 data, 2 debugger |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Word to program |
| wbuf_idx | output | 5 | Burst word index being written |
| wbuf_data | input | DW | Burst word for the current `wbuf_idx` |
| pol_we | input | 1 | Policy write strobe |
| pol_kind | input | 1 | 0 modify vector, 1 read vector |
| pol_data | input | NUM_BLKS/2 | Bits ANDed into the chosen vector |
| busy | output | 1 | Erase or burst in progress |
| done | output | 1 | One-cycle completion pulse |
| viol | output | 1 | One-cycle refusal pulse |
| rd_data | output | DW | Read result, zero unless a read was allowed |

## Verification
The assertions assume that `req_addr` stays inside the array, that `req_op` and `req_src` hold the listed codes, and that no request is expected to be accepted while `busy` is high. They also assume that `wbuf_data` is valid for the index the block presents in the same cycle. The stimulus respects these assumptions. It waits for `busy` to drop before each scored request and drives `wbuf_data` combinationally from `wbuf_idx`. It uses only in-range addresses and defined codes. The one deliberate exception is a single request issued during an erase, which checks that the block ignores it.

// File: rtl/flash_prot_pkg.sv
// Package: shared request, requester and sequencer codes for the
// flash protection controller. Assumes 2-bit op and source fields.
package flash_prot_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_BURST = 2'd3
    } fp_op_e;

    typedef enum logic [1:0] {
        SRC_FETCH = 2'd0,
        SRC_DATA  = 2'd1,
        SRC_DEBUG = 2'd2
    } fp_src_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ERASE = 2'd1,
        ST_BURST = 2'd2
    } fp_state_e;

endpackage

// File: rtl/flash_policy.sv
// Module: flash_policy
// Holds one modify bit and one read bit per protection region.
// Both vectors are all ones after reset. Writes can only clear bits.
// Looks up the bits for the region addressed by the current request.
// Assumes that a region spans two erase blocks of WORDS_PER_BLK words.
module flash_policy #(
    parameter int NUM_BLKS      = 4,
    parameter int WORDS_PER_BLK = 256,
    localparam int NR = NUM_BLKS / 2,
    localparam int AW = $clog2(NUM_BLKS * WORDS_PER_BLK),
    localparam int CW = $clog2(WORDS_PER_BLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pol_we,
    input  logic          pol_kind,
    input  logic [NR-1:0] pol_data,
    input  logic [AW-1:0] lk_addr,
    output logic          lk_mod_ok,
    output logic          lk_rd_ok,
    output logic [NR-1:0] mod_vec
);

    logic [NR-1:0] mod_q;
    logic [NR-1:0] rd_q;

    // One bit pair per region; each bit can only fall until reset.
    for (genvar g = 0; g < NR; g++) begin : g_region
        // Purpose: clear the region's modify bit on a matching policy write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mod_q[g] <= 1'b1;
            else if (pol_we && !pol_kind)
                mod_q[g] <= mod_q[g] & pol_data[g];
        end

        // Purpose: clear the region's read bit on a matching policy write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_q[g] <= 1'b1;
            else if (pol_we && pol_kind)
                rd_q[g] <= rd_q[g] & pol_data[g];
        end
    end

    logic [AW-CW-2:0] lk_region;

    // Purpose: select the region bits for the looked-up address.
    always_comb begin
        lk_region = lk_addr[AW-1:CW+1];
        lk_mod_ok = mod_q[lk_region];
        lk_rd_ok  = rd_q[lk_region];
    end

    assign mod_vec = mod_q;

    // R10
    mod_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_q & ~$past(mod_q)) == '0);
    // R10
    rd_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q & ~$past(rd_q)) == '0);

endmodule

// File: rtl/flash_array.sv
// Module: flash_array
// Register model of the flash array. Reset fills it with all ones.
// A write either forces the word to all ones (erase) or ANDs the new data in (program).
// It has one write port and one combinational read port.
// Assumes that the same word is never written on two consecutive cycles.
module flash_array #(
    parameter int DEPTH = 1024,
    parameter int DW    = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          we_ones,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Purpose: reset to the erased state, then apply erase or AND-program writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '1;
        end else if (we) begin
            mem[waddr] <= we_ones ? '1 : (mem[waddr] & wdata);
        end
    end

    assign rdata = mem[raddr];

    // Checker state: remember the last write so its result can be inspected.
    logic          chk_vld;
    logic          chk_ones;
    logic [AW-1:0] chk_addr;
    logic [DW-1:0] chk_old;

    // Purpose: record the address, kind and prior value of each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_vld  <= 1'b0;
            chk_ones <= 1'b0;
            chk_addr <= '0;
            chk_old  <= '0;
        end else begin
            chk_vld  <= we;
            chk_ones <= we_ones;
            chk_addr <= waddr;
            chk_old  <= mem[waddr];
        end
    end

    // R2
    prog_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld && !chk_ones) |-> ((mem[chk_addr] & ~chk_old) == '0));
    // R1
    erase_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_vld && chk_ones) |-> (&mem[chk_addr]));

endmodule

// File: rtl/flash_seq.sv
// Module: flash_seq
// Accepts requests while idle and applies the policy verdicts.
// It runs erase and burst programming one word per cycle.
// It produces the done, violation and read-data outputs.
// Assumes that the policy verdicts refer to req_addr in the same cycle.
module flash_seq
    import flash_prot_pkg::*;
#(
    parameter int NUM_BLKS      = 4,
    parameter int WORDS_PER_BLK = 256,
    parameter int DW            = 32,
    parameter int BURST_LEN     = 32,
    localparam int AW = $clog2(NUM_BLKS * WORDS_PER_BLK),
    localparam int CW = $clog2(WORDS_PER_BLK),
    localparam int BW = $clog2(BURST_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [1:0]    req_src,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          mod_ok,
    input  logic          rd_ok,
    input  logic [DW-1:0] arr_rdata,
    input  logic [DW-1:0] wbuf_data,
    output logic [BW-1:0] wbuf_idx,
    output logic          arr_we,
    output logic          arr_ones,
    output logic [AW-1:0] arr_waddr,
    output logic [DW-1:0] arr_wdata,
    output logic          busy,
    output logic          done,
    output logic          viol,
    output logic [DW-1:0] rd_data
);

    localparam logic [CW-1:0] ERASE_LAST = CW'(WORDS_PER_BLK - 1);
    localparam logic [BW-1:0] BURST_LAST = BW'(BURST_LEN - 1);

    fp_state_e        state_q;
    logic [CW-1:0]    cnt_q;
    logic [AW-CW-1:0] blk_q;
    logic [AW-BW-1:0] base_q;

    fp_op_e  op;
    fp_src_e src;
    logic    accept;
    logic    rd_grant;

    // Purpose: decode the incoming request and its read verdict.
    always_comb begin
        op       = fp_op_e'(req_op);
        src      = fp_src_e'(req_src);
        accept   = req_valid && (state_q == ST_IDLE);
        rd_grant = rd_ok || (src == SRC_FETCH);
    end

    // Purpose: steer the array write port by sequencer state.
    always_comb begin
        arr_we    = 1'b0;
        arr_ones  = 1'b0;
        arr_waddr = req_addr;
        arr_wdata = req_wdata;
        unique case (state_q)
            ST_ERASE: begin
                arr_we    = 1'b1;
                arr_ones  = 1'b1;
                arr_waddr = {blk_q, cnt_q};
            end
            ST_BURST: begin
                arr_we    = 1'b1;
                arr_waddr = {base_q, cnt_q[BW-1:0]};
                arr_wdata = wbuf_data;
            end
            default: begin
                arr_we = accept && (op == OP_PROG) && mod_ok;
            end
        endcase
    end

    assign wbuf_idx = cnt_q[BW-1:0];
    assign busy     = (state_q != ST_IDLE);

    // Purpose: track the sequencer state, word counter and saved block base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            blk_q   <= '0;
            base_q  <= '0;
        end else begin
            unique case (state_q)
                ST_ERASE: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == ERASE_LAST)
                        state_q <= ST_IDLE;
                end
                ST_BURST: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q[BW-1:0] == BURST_LAST)
                        state_q <= ST_IDLE;
                end
                default: begin
                    cnt_q <= '0;
                    if (accept && mod_ok && (op == OP_ERASE)) begin
                        state_q <= ST_ERASE;
                        blk_q   <= req_addr[AW-1:CW];
                    end
                    if (accept && mod_ok && (op == OP_BURST)) begin
                        state_q <= ST_BURST;
                        base_q  <= req_addr[AW-1:BW];
                    end
                end
            endcase
        end
    end

    // Purpose: generate done/violation pulses and capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            viol    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            viol <= 1'b0;
            if (state_q == ST_ERASE && cnt_q == ERASE_LAST)
                done <= 1'b1;
            if (state_q == ST_BURST && cnt_q[BW-1:0] == BURST_LAST)
                done <= 1'b1;
            if (accept) begin
                rd_data <= '0;
                unique case (op)
                    OP_READ: begin
                        done <= 1'b1;
                        viol <= !rd_grant;
                        if (rd_grant)
                            rd_data <= arr_rdata;
                    end
                    OP_PROG: begin
                        done <= 1'b1;
                        viol <= !mod_ok;
                    end
                    default: begin
                        if (!mod_ok) begin
                            done <= 1'b1;
                            viol <= 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R8
    viol_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> (done && rd_data == '0));
    // R8
    viol_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> !viol || $past(accept));
    // R11
    busy_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(busy, 2) && req_valid) |=> !viol);
    // R1
    erase_writes_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERASE) |-> (arr_we && arr_ones));

endmodule

// File: rtl/flash_prot_ctrl.sv
// Module: flash_prot_ctrl (top)
// Flash protection controller. It connects the per-region policy store,
// the request sequencer and the flash array model.
// Assumes in-range addresses, defined op/source codes, and a power-of-two NUM_BLKS of at least 4.
module flash_prot_ctrl #(
    parameter int NUM_BLKS      = 4,
    parameter int WORDS_PER_BLK = 256,
    parameter int DW            = 32,
    parameter int BURST_LEN     = 32,
    localparam int NR    = NUM_BLKS / 2,
    localparam int DEPTH = NUM_BLKS * WORDS_PER_BLK,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(WORDS_PER_BLK),
    localparam int BW    = $clog2(BURST_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [1:0]    req_src,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [BW-1:0] wbuf_idx,
    input  logic [DW-1:0] wbuf_data,
    input  logic          pol_we,
    input  logic          pol_kind,
    input  logic [NR-1:0] pol_data,
    output logic          busy,
    output logic          done,
    output logic          viol,
    output logic [DW-1:0] rd_data
);

    logic          mod_ok;
    logic          rd_ok;
    logic [NR-1:0] mod_vec;
    logic          arr_we;
    logic          arr_ones;
    logic [AW-1:0] arr_waddr;
    logic [DW-1:0] arr_wdata;
    logic [DW-1:0] arr_rdata;

    flash_policy #(
        .NUM_BLKS      (NUM_BLKS),
        .WORDS_PER_BLK (WORDS_PER_BLK)
    ) u_policy (
        .clk       (clk),
        .rst_n     (rst_n),
        .pol_we    (pol_we),
        .pol_kind  (pol_kind),
        .pol_data  (pol_data),
        .lk_addr   (req_addr),
        .lk_mod_ok (mod_ok),
        .lk_rd_ok  (rd_ok),
        .mod_vec   (mod_vec)
    );

    flash_seq #(
        .NUM_BLKS      (NUM_BLKS),
        .WORDS_PER_BLK (WORDS_PER_BLK),
        .DW            (DW),
        .BURST_LEN     (BURST_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_src   (req_src),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mod_ok    (mod_ok),
        .rd_ok     (rd_ok),
        .arr_rdata (arr_rdata),
        .wbuf_data (wbuf_data),
        .wbuf_idx  (wbuf_idx),
        .arr_we    (arr_we),
        .arr_ones  (arr_ones),
        .arr_waddr (arr_waddr),
        .arr_wdata (arr_wdata),
        .busy      (busy),
        .done      (done),
        .viol      (viol),
        .rd_data   (rd_data)
    );

    flash_array #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (arr_we),
        .we_ones (arr_ones),
        .waddr   (arr_waddr),
        .wdata   (arr_wdata),
        .raddr   (req_addr),
        .rdata   (arr_rdata)
    );

    // R4
    write_needs_mod_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> mod_vec[arr_waddr[AW-1:CW+1]]);
    // R3
    erase_stays_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && arr_ones && $past(arr_we && arr_ones))
            |-> (arr_waddr[AW-1:CW] == $past(arr_waddr[AW-1:CW])));

endmodule

// File: tb/flash_prot_ctrl_bench.sv
// Scoreboard bench: the driver computes expected results from its own
// array/policy model and queues them; the monitor compares on each done.
module flash_prot_ctrl_bench;

    localparam int NB  = 4;
    localparam int WPB = 256;
    localparam int DW  = 32;
    localparam int BL  = 32;
    localparam int NR  = NB / 2;
    localparam int DEP = NB * WPB;
    localparam int AW  = $clog2(DEP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [1:0]    req_src = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [4:0]    wbuf_idx;
    logic [DW-1:0] wbuf_data;
    logic          pol_we = 1'b0;
    logic          pol_kind = 1'b0;
    logic [NR-1:0] pol_data = '0;
    logic          busy, done, viol;
    logic [DW-1:0] rd_data;

    flash_prot_ctrl #(.NUM_BLKS(NB), .WORDS_PER_BLK(WPB), .DW(DW), .BURST_LEN(BL))
    u_flash_prot_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_src(req_src), .req_addr(req_addr), .req_wdata(req_wdata),
        .wbuf_idx(wbuf_idx), .wbuf_data(wbuf_data), .pol_we(pol_we),
        .pol_kind(pol_kind), .pol_data(pol_data), .busy(busy), .done(done),
        .viol(viol), .rd_data(rd_data)
    );

    always #2 clk = ~clk;  // 250 MHz

    function automatic logic [DW-1:0] bdat(input logic [4:0] i);
        return 32'hA5C3_0F96 ^ ({27'd0, i} << 9) ^ {27'd0, i};
    endfunction
    assign wbuf_data = bdat(wbuf_idx);

    typedef struct { logic v; logic [DW-1:0] d; string tag; } exp_t;
    exp_t          sb[$];
    int            nchk = 0;
    int            nfail = 0;
    logic [DW-1:0] m_mem [DEP];
    logic [NR-1:0] m_mod = '1;
    logic [NR-1:0] m_rd  = '1;
    int            lat;

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per done pulse and compare.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R12/R11 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(viol == e.v, {e.tag, " viol"}, {31'd0, viol}, {31'd0, e.v});
                check(rd_data == e.d, {e.tag, " data"}, rd_data, e.d);
            end
        end else if (rst_n && viol) begin
            check(1'b0, "R8 viol without done", 32'd1, 32'd0);
        end
    end

    task automatic polw(input logic kind, input logic [NR-1:0] d);
        @(negedge clk);
        pol_we = 1'b1; pol_kind = kind; pol_data = d;
        if (kind) m_rd = m_rd & d; else m_mod = m_mod & d;
        @(negedge clk);
        pol_we = 1'b0;
    endtask

    // Start a request: compute the expected result, update the model, drive for one cycle.
    task automatic start(input logic [1:0] op, input logic [1:0] src, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input string tag);
        exp_t e;
        int r;
        @(negedge clk);
        while (busy) @(negedge clk);
        r = int'(a) / (2 * WPB);
        e.tag = tag; e.v = 1'b0; e.d = '0;
        case (op)
            2'd0: if (m_rd[r] || src == 2'd0) e.d = m_mem[a]; else e.v = 1'b1;
            2'd1: if (m_mod[r]) m_mem[a] = m_mem[a] & wd; else e.v = 1'b1;
            2'd2: if (m_mod[r]) begin
                      for (int i = 0; i < WPB; i++) m_mem[(int'(a) / WPB) * WPB + i] = '1;
                  end else e.v = 1'b1;
            default: if (m_mod[r]) begin
                      for (int i = 0; i < BL; i++)
                          m_mem[(int'(a) / BL) * BL + i] = m_mem[(int'(a) / BL) * BL + i] & bdat(5'(i));
                  end else e.v = 1'b1;
        endcase
        sb.push_back(e);
        req_valid = 1'b1; req_op = op; req_src = src; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
    endtask

    task automatic finish_wait;
        while (!done) begin @(negedge clk); lat++; end
    endtask

    task automatic req(input logic [1:0] op, input logic [1:0] src, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input string tag);
        start(op, src, a, wd, tag);
        finish_wait();
    endtask

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog expired", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEP; i++) m_mem[i] = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(!busy && !done && !viol, "R9 idle after reset", {29'd0, busy, done, viol}, 32'd0);
        req(2'd0, 2'd2, 10'h000, '0, "R9 erased read");
        // R2: AND programming, R12 single done each
        req(2'd1, 2'd1, 10'h005, 32'h1234_5678, "R2 program");
        req(2'd0, 2'd1, 10'h005, '0, "R2 readback");
        req(2'd1, 2'd1, 10'h005, 32'hFFFF_0000, "R2 and");
        req(2'd1, 2'd1, 10'h005, 32'hFFFF_FFFF, "R2 no set");
        req(2'd0, 2'd0, 10'h005, '0, "R2 readback2");
        req(2'd1, 2'd1, 10'h0FF, 32'h0000_0000, "R2 zero");
        // R1: erase block 0 with an ignored request (R11) in the middle
        start(2'd2, 2'd1, 10'h010, '0, "R1 erase");
        check(busy == 1'b1, "R11 busy during erase", {31'd0, busy}, 32'd1);
        req_valid = 1'b1; req_op = 2'd1; req_src = 2'd1; req_addr = 10'h300; req_wdata = '0;
        @(negedge clk); lat++;
        req_valid = 1'b0;
        finish_wait();
        check(lat == WPB + 1, "R1 erase latency", 32'(lat), 32'(WPB + 1));
        req(2'd0, 2'd1, 10'h005, '0, "R1 word erased");
        req(2'd0, 2'd1, 10'h0FF, '0, "R1 last word erased");
        req(2'd0, 2'd1, 10'h300, '0, "R11 ignored program");
        // R7: burst program, unaligned start address
        start(2'd3, 2'd1, 10'h205, '0, "R7 burst");
        finish_wait();
        check(lat == BL + 1, "R7 burst latency", 32'(lat), 32'(BL + 1));
        req(2'd0, 2'd1, 10'h200, '0, "R7 first word");
        req(2'd0, 2'd1, 10'h21F, '0, "R7 last word");
        req(2'd0, 2'd1, 10'h220, '0, "R7 beyond burst");
        // R3/R4/R5: region 0 made read-only
        req(2'd1, 2'd1, 10'h100, 32'h5A5A_F00F, "R2 block1 program");
        polw(1'b0, 2'b10);
        req(2'd1, 2'd1, 10'h100, 32'h0000_0000, "R4 program refused");
        req(2'd2, 2'd1, 10'h000, '0, "R4 erase refused");
        req(2'd3, 2'd1, 10'h120, '0, "R4 burst refused");
        req(2'd0, 2'd2, 10'h100, '0, "R5 debug read");
        req(2'd0, 2'd1, 10'h005, '0, "R5 data read");
        req(2'd1, 2'd1, 10'h2F0, 32'h0F0F_0F0F, "R3 region1 open");
        req(2'd0, 2'd1, 10'h2F0, '0, "R3 region1 read");
        // R10: writing ones cannot reopen
        polw(1'b0, 2'b11);
        req(2'd1, 2'd1, 10'h100, 32'h0, "R10 still closed");
        // R6: execute-only
        polw(1'b1, 2'b10);
        req(2'd0, 2'd0, 10'h100, '0, "R6 fetch read");
        req(2'd0, 2'd1, 10'h100, '0, "R6 data refused");
        req(2'd0, 2'd2, 10'h100, '0, "R6 debug refused");
        req(2'd0, 2'd1, 10'h2F0, '0, "R6 region1 readable");
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R12 all done seen", 32'(sb.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule